// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

The framer takes a 7-bit character from a parallel bus and sends it as an asynchronous frame on one serial line. Each frame has a low start bit, then the seven data bits starting with the least significant one, then an optional parity bit, then one, one and a half or two high stop periods. The line rests high between frames.

Bit timing comes from an external enable that pulses sixteen times per bit period. A full bit lasts sixteen of these ticks and the half stop period lasts eight, so no baud divider is built in. A load strobe is accepted only while the ready flag is high. The character, the parity mode and the stop length are captured at that moment. Ready drops for the whole frame and rises again on the tick that ends the last stop period, so the next frame can start on the following cycle.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `ready` is 1.
- R2: A load accepted while `ready` is 1 drives `txd` to 0 (start bit) from the next cycle. The start bit lasts 16 ticks, and `ready` is 0 from that same cycle.
- R3: After the start bit come the seven data bits, bit 0 first and bit 6 last, each lasting 16 ticks.
- R4: With `par_mode` = 2'b01 (even), a parity bit lasting 16 ticks follows bit 6. Its value makes the number of ones in data plus parity even.
- R5: With `par_mode` = 2'b10 (odd), the parity bit makes the number of ones in data plus parity odd.
- R6: With `par_mode` = 2'b00 or 2'b11 (none), no parity period is sent and the stop period follows bit 6 directly.
- R7: The stop period is high for 16 ticks when `stop_sel` = 2'b00, 24 ticks when it is 2'b01, and 32 ticks when it is 2'b10 or 2'b11.
- R8: A load while `ready` is 0 is ignored: the frame in progress keeps its timing and content, and no extra frame follows.
- R9: Changes to `data_in`, `par_mode` or `stop_sel` after a load do not affect the frame in progress.
- R10: `ready` returns to 1 in the cycle after the tick that ends the last stop period. A load in that cycle starts the next frame at once.
- R11: Timing advances only on cycles where `tick16` is 1. Without ticks, `txd` and the remaining bit time hold.
- R12: The character 0x45 with even parity and two stop bits produces the line sequence 0,1,0,1,0,0,0,1,1,1,1 in bit periods.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Enable at sixteen times the bit rate |
| load | input | 1 | Strobe that requests transmission of `data_in` |
| data_in | input | 7 | Character to send |
| par_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| stop_sel | input | 2 | 00 one, 01 one and a half, 10 or 11 two stop bits |
| txd | output | 1 | Serial line, high at rest |
| ready | output | 1 | High when a load will be accepted |

## Verification
The risky overlap is a load strobe that arrives on the same edge as the tick that ends the last stop period. At that edge the framer is still busy, so the load must be dropped and only a load one cycle later may start a frame. The bench holds load high across the end of a frame, with the tick enable running every cycle, and also changes configuration in the middle of a frame. A behavioural model that keeps a queue of line levels and tick counts is compared with `txd` and `ready` on every cycle, and directed counts of frame length confirm how many cycles `ready` stays low.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [2:0] {
    FS_IDLE   = 3'd0,
    FS_START  = 3'd1,
    FS_DATA   = 3'd2,
    FS_PARITY = 3'd3,
    FS_STOP   = 3'd4
  } ftx_state_e;

  // parity mode encodings
  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  // stop length encodings
  localparam logic [1:0] SL_ONE  = 2'b00;
  localparam logic [1:0] SL_HALF = 2'b01;

  function automatic logic ftx_has_parity(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

  // parity bit that brings the ones-count of data plus parity to the wanted sense
  function automatic logic ftx_parity_bit(input logic [6:0] d, input logic [1:0] mode);
    logic ones_odd;
    ones_odd = ^d;
    return (mode == PM_ODD) ? ~ones_odd : ones_odd;
  endfunction

  // length of the stop period in ticks
  function automatic int ftx_stop_ticks(input logic [1:0] sel, input int os);
    case (sel)
      SL_ONE:  return os;
      SL_HALF: return os + os / 2;
      default: return 2 * os;
    endcase
  endfunction

endpackage

// File: rtl/ftx_bit_timer.sv
module ftx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             bit_end
);

  logic [CNT_W-1:0] cnt;

  assign bit_end = run && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || bit_end) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt)); // R11

  AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit)); // R7

endmodule

// File: rtl/ftx_sequencer.sv
module ftx_sequencer
  import ftx_pkg::*;
#(
  parameter int DATA_W     = 7,
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        par_mode,
  input  logic [1:0]        stop_sel,
  input  logic              bit_end,
  output logic              accept,
  output logic              busy,
  output logic [CNT_W-1:0]  limit,
  output logic              txd,
  output logic              frame_done
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  ftx_state_e        state;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              par_q;
  logic              has_par_q;
  logic [CNT_W-1:0]  stop_len_q;

  assign busy       = (state != FS_IDLE);
  assign accept     = load && !busy;
  assign frame_done = bit_end && (state == FS_STOP);
  assign limit      = (state == FS_STOP) ? stop_len_q : CNT_W'(OVERSAMPLE);

  always_comb begin
    case (state)
      FS_START:  txd = 1'b0;
      FS_DATA:   txd = shreg[0];
      FS_PARITY: txd = par_q;
      default:   txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FS_IDLE;
      shreg      <= '0;
      idx        <= '0;
      par_q      <= 1'b0;
      has_par_q  <= 1'b0;
      stop_len_q <= CNT_W'(OVERSAMPLE);
    end else if (accept) begin
      state      <= FS_START;
      shreg      <= data_in;
      idx        <= '0;
      par_q      <= ftx_parity_bit(7'(data_in), par_mode);
      has_par_q  <= ftx_has_parity(par_mode);
      stop_len_q <= CNT_W'(ftx_stop_ticks(stop_sel, OVERSAMPLE));
    end else if (bit_end) begin
      case (state)
        FS_START: begin
          state <= FS_DATA;
          idx   <= '0;
        end
        FS_DATA: begin
          if (idx == LAST_IDX) begin
            state <= has_par_q ? FS_PARITY : FS_STOP;
          end else begin
            idx   <= idx + IDX_W'(1);
            shreg <= shreg >> 1;
          end
        end
        FS_PARITY: state <= FS_STOP;
        default:   state <= FS_IDLE;
      endcase
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd && busy)); // R2

  AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> ($stable(has_par_q) && $stable(par_q) && $stable(stop_len_q))); // R9

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy); // R10

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !bit_end) |=> $stable(state)); // R8

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
  parameter int DATA_W     = 7,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        par_mode,
  input  logic [1:0]        stop_sel,
  output logic              txd,
  output logic              ready
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);

  logic             accept;
  logic             busy;
  logic             bit_end;
  logic             frame_done;
  logic [CNT_W-1:0] limit;

  ftx_sequencer #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .data_in   (data_in),
    .par_mode  (par_mode),
    .stop_sel  (stop_sel),
    .bit_end   (bit_end),
    .accept    (accept),
    .busy      (busy),
    .limit     (limit),
    .txd       (txd),
    .frame_done(frame_done)
  );

  ftx_bit_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .clear  (accept),
    .run    (busy),
    .limit  (limit),
    .bit_end(bit_end)
  );

  assign ready = !busy;

  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load) |=> !ready); // R2

  AST_NO_TICK_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !(ready && load)) |=> ($stable(txd) && $stable(ready))); // R11

endmodule

// File: tb/tb_async_frame_tx.sv
module tb_async_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       load = 1'b0;
  logic [6:0] data_in = '0;
  logic [1:0] par_mode = '0;
  logic [1:0] stop_sel = '0;
  logic       txd;
  logic       ready;

  int compared = 0;
  int mismatched = 0;
  int tick_div = 1;   // 0: no ticks, n: one tick every n cycles
  int tick_ph = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  async_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load),
    .data_in(data_in), .par_mode(par_mode), .stop_sel(stop_sel),
    .txd(txd), .ready(ready)
  );

  // tick driver
  always @(posedge clk) begin
    #1;
    if (tick_div == 0) tick16 = 1'b0;
    else begin
      tick16 = (tick_ph == 0);
      tick_ph = (tick_ph + 1) % tick_div;
    end
  end

  // behavioural reference model: queue of (level, ticks) periods
  int  lvl_q[$];
  int  len_q[$];
  bit  m_busy = 0;

  function automatic void m_build(input logic [6:0] d, input logic [1:0] pm, input logic [1:0] ss);
    int ones = 0;
    lvl_q.push_back(0); len_q.push_back(16);
    for (int i = 0; i < 7; i++) begin
      lvl_q.push_back(int'(d[i])); len_q.push_back(16);
      ones += int'(d[i]);
    end
    if (pm == 2'b01) begin lvl_q.push_back(ones % 2); len_q.push_back(16); end
    if (pm == 2'b10) begin lvl_q.push_back(1 - ones % 2); len_q.push_back(16); end
    lvl_q.push_back(1);
    len_q.push_back(ss == 2'b00 ? 16 : (ss == 2'b01 ? 24 : 32));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_q.delete(); len_q.delete(); m_busy = 0;
    end else if (!m_busy) begin
      if (load) begin m_build(data_in, par_mode, stop_sel); m_busy = 1; end
    end else if (tick16) begin
      len_q[0] = len_q[0] - 1;
      if (len_q[0] == 0) begin
        void'(lvl_q.pop_front()); void'(len_q.pop_front());
        if (lvl_q.size() == 0) m_busy = 0;
      end
    end
  end

  // per-cycle comparison (covers R1..R11 continuously)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic m_txd;
      m_txd = m_busy ? logic'(lvl_q[0][0]) : 1'b1;
      compared++;
      if (txd !== m_txd || ready !== !m_busy) begin
        mismatched++;
        $display("FAIL cycle compare R11 t=%0t: txd=%b ready=%b expected txd=%b ready=%b",
                 $time, txd, ready, m_txd, !m_busy);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] d, input logic [1:0] pm, input logic [1:0] ss);
    @(posedge clk); #1;
    data_in = d; par_mode = pm; stop_sel = ss; load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  // count cycles ready stays low after an accept (tick every cycle)
  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (ready == 1'b0 && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic int exp_len(input logic [1:0] pm, input logic [1:0] ss);
    int p = (pm == 2'b01 || pm == 2'b10) ? 1 : 0;
    int s = (ss == 2'b00) ? 16 : (ss == 2'b01) ? 24 : 32;
    return 16 * (8 + p) + s;
  endfunction

  initial begin : watchdog
    while (cycles < 150000 && !done) begin @(posedge clk); cycles++; end
    if (!done) begin
      done = 1;
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    int n;
    logic [10:0] e_seq;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R1 idle txd", int'(txd), 1);
    check(ready === 1'b1, "R1 idle ready", int'(ready), 1);

    // R12 / R3 / R4 / R9: 'E' even two stop, sampled mid-bit, config changed mid-frame
    tick_div = 1;
    e_seq = 11'b11110001010;  // bit 0 first: 0,1,0,1,0,0,0,1,1,1,1
    do_load(7'h45, 2'b01, 2'b10);
    data_in = 7'h3A; par_mode = 2'b10; stop_sel = 2'b00;  // R9 mid-frame change
    repeat (7) @(negedge clk);
    for (int b = 0; b < 11; b++) begin
      check(txd === e_seq[b], $sformatf("R12 R3 bit %0d", b), int'(txd), int'(e_seq[b]));
      if (b < 10) repeat (16) @(negedge clk);
    end
    wait (ready == 1'b1);

    // R7 / R6 / R5 / R4: frame lengths for each configuration
    for (int pm = 0; pm < 4; pm++) begin
      for (int ss = 0; ss < 4; ss++) begin
        do_load(7'h5B, 2'(pm), 2'(ss));
        busy_len(n);
        check(n == exp_len(2'(pm), 2'(ss)),
              $sformatf("R7 R6 length pm=%0d ss=%0d", pm, ss), n, exp_len(2'(pm), 2'(ss)));
      end
    end

    // R5 odd parity value for 0x45 (3 ones -> parity 0)
    do_load(7'h45, 2'b10, 2'b00);
    repeat (7 + 16 * 8) @(negedge clk);
    check(txd === 1'b0, "R5 odd parity bit", int'(txd), 0);
    // R4 even parity for 0x03 (2 ones -> 0)
    wait (ready == 1'b1);
    do_load(7'h03, 2'b01, 2'b00);
    repeat (7 + 16 * 8) @(negedge clk);
    check(txd === 1'b0, "R4 even parity bit", int'(txd), 0);
    // R6 no parity: period after D6 is stop (high)
    wait (ready == 1'b1);
    do_load(7'h00, 2'b11, 2'b00);
    repeat (7 + 16 * 8) @(negedge clk);
    check(txd === 1'b1, "R6 stop follows D6", int'(txd), 1);
    wait (ready == 1'b1);

    // R8 / R10: load held high across frame end; length unchanged, next frame right after
    @(posedge clk); #1;
    data_in = 7'h7F; par_mode = 2'b00; stop_sel = 2'b00; load = 1'b1;
    @(posedge clk); #1;  // accepted here, load stays high
    busy_len(n);
    check(n == exp_len(2'b00, 2'b00), "R8 length with load held", n, exp_len(2'b00, 2'b00));
    // ready high this cycle; load still high -> next edge starts next frame
    @(negedge clk);
    check(ready === 1'b0, "R10 back-to-back restart", int'(ready), 0);
    check(txd === 1'b0, "R10 start bit of next frame", int'(txd), 0);
    #1 load = 1'b0;
    wait (ready == 1'b1);

    // R11: stalled ticks hold the line
    tick_div = 3;
    do_load(7'h2C, 2'b01, 2'b01);
    repeat (20) @(negedge clk);
    tick_div = 0;
    @(negedge clk);
    begin
      logic hold_txd;
      hold_txd = txd;
      repeat (40) @(negedge clk);
      check(txd === hold_txd && ready === 1'b0, "R11 hold without tick", int'(txd), int'(hold_txd));
    end
    tick_div = 1;
    wait (ready == 1'b1);

    // random frames with random tick rates and stray loads (model compared each cycle)
    for (int k = 0; k < 40; k++) begin
      tick_div = 1 + int'($urandom_range(0, 3));
      do_load(7'($urandom), 2'($urandom), 2'($urandom));
      for (int c = 0; c < 200; c++) begin
        @(posedge clk); #1;
        load = ($urandom_range(0, 15) == 0);
        data_in = 7'($urandom); par_mode = 2'($urandom); stop_sel = 2'($urandom);
      end
      load = 1'b0;
      wait (ready == 1'b1);
    end

    repeat (5) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule